// File: doc/BRIEF.md
# Step Attenuator Serial Programmer

This block sits in a host device and programs a digital step attenuator through the attenuator's three-wire serial port: a clock, a data line and a latch strobe. A client offers an attenuation request with a valid/ready handshake. The request is given in quarter-step units, so 12.5 units of attenuation arrive as the code 50. The block turns the request into an 8-bit control word and shifts it out least significant bit first, with the strobe held low. It then pulses the strobe high to commit the word into the attenuator.

Every minimum time the attenuator asks for is a parameter counted in system-clock cycles, rounded up by the integrator. These times are clock high time, clock low time, the serial clock period, data setup and hold, the delay from the last clock rise to the strobe, and the strobe width. A further parameter sets the dead time after each commit. That dead time keeps the attenuation from changing faster than the attenuator allows (25 kHz). Requests above the largest 7-bit code are saturated, and a flag reports the saturation.

Top module: `atten_serial_prog`

## Requirements
- R1: The transmitted word carries the 7-bit code in bits [6:0] and a 0 in bit 7; the request 50 sends 8'b0011_0010.
- R2: A request above 127 is sent as 127 and sets `clamped` in the cycle after acceptance; `clamped` keeps the value of the latest accepted request and is 0 after a request of 127 or less.
- R3: Each transfer makes exactly 8 rising edges on `ser_clk`, and on the n-th rising edge `ser_data` carries word bit n-1 (bit 0 first).
- R4: `ser_le` stays low until all 8 rising edges have occurred, then goes high exactly once per transfer for `LE_PULSE_CYC` cycles, with `ser_clk` low for the whole pulse.
- R5: Every high phase of `ser_clk` lasts exactly `SCLK_HI_CYC` cycles, and `ser_clk` has been low for at least `SCLK_LO_CYC` cycles before each rise.
- R6: `ser_data` changes only when `ser_clk` falls or while it is low, so it is steady from at least `SCLK_LO_CYC` cycles before each rise until `SCLK_HI_CYC` cycles after it.
- R7: `ser_le` rises exactly `SCLK_HI_CYC + LE_SETUP_CYC` cycles after the last rise of `ser_clk`.
- R8: `req_ready` drops in the cycle after a request is accepted and returns exactly `GAP_CYC` cycles after `ser_le` falls; `busy` is always the inverse of `req_ready`.
- R9: After reset and whenever idle, `ser_clk`, `ser_data` and `ser_le` are low, `req_ready` is high and `clamped` is low.
- R10: A `req_valid` raised while `req_ready` is low is ignored: it starts no transfer, does not change the word in flight and does not change `clamped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_value | input | REQ_W | Requested attenuation in quarter-step units |
| req_ready | output | 1 | Block can accept a request this cycle |
| busy | output | 1 | Transfer or dead time in progress |
| clamped | output | 1 | Last accepted request was saturated to 127 |
| ser_clk | output | 1 | Serial clock to the attenuator, idles low |
| ser_data | output | 1 | Serial data to the attenuator, idles low |
| ser_le | output | 1 | Latch strobe to the attenuator |

## Verification
The assertions assume that reset is asserted from time zero, so the first observed values of the serial pins are their reset values. They also assume that `req_valid` and `req_value` are synchronous to `clk`. They do not assume that a request is held: the bench raises `req_valid` for a single cycle when `req_ready` is high, and it pulses it deliberately while busy to show that such requests are dropped. All inputs change on the falling edge, so the handshake is sampled cleanly at the rising edge.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LO,
      ST_HI,
      ST_LESU,
      ST_LEHI,
      ST_GAP
   } seq_state_t;

   function automatic int cyc_max(input int a, input int b, input int c,
                                  input int d, input int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction

endpackage

// File: rtl/atten_word_build.sv
module atten_word_build #(
   parameter int REQ_W  = 8,
   parameter int CODE_W = 7
) (
   input  logic [REQ_W-1:0]  req_value,
   output logic [CODE_W:0]   word,
   output logic              over
);
   logic [CODE_W-1:0] code;

   generate
      if (REQ_W > CODE_W) begin : g_clamp
         assign over = |req_value[REQ_W-1:CODE_W];
         assign code = over ? {CODE_W{1'b1}} : req_value[CODE_W-1:0];
      end else begin : g_direct
         assign over = 1'b0;
         assign code = CODE_W'(req_value);
      end
   endgenerate

   // bit above the code is a don't-care on the wire; always sent as 0
   assign word = {1'b0, code};

endmodule

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/atten_shift_seq.sv
module atten_shift_seq
   import atten_prog_pkg::*;
#(
   parameter int WORD_W       = 8,
   parameter int TW           = 4,
   parameter int SCLK_HI_CYC  = 2,
   parameter int SCLK_LO_CYC  = 3,
   parameter int LE_SETUP_CYC = 1,
   parameter int LE_PULSE_CYC = 2,
   parameter int GAP_CYC      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] word,
   input  logic              expired,
   output logic              load,
   output logic [TW-1:0]     load_val,
   output logic              ready,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_le
);
   localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   seq_state_t        state, nxt;
   logic [WORD_W-1:0] shreg;
   logic [BW-1:0]     bit_idx;
   logic              last_bit;
   logic              accept;

   assign ready    = (state == ST_IDLE);
   assign accept   = ready && req_valid;
   assign last_bit = (bit_idx == BW'(WORD_W-1));

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_val = '0;
      unique case (state)
         ST_IDLE: if (accept) begin
            nxt = ST_LO; load = 1'b1; load_val = TW'(SCLK_LO_CYC-1);
         end
         ST_LO: if (expired) begin
            nxt = ST_HI; load = 1'b1; load_val = TW'(SCLK_HI_CYC-1);
         end
         ST_HI: if (expired) begin
            load = 1'b1;
            if (last_bit) begin
               nxt = ST_LESU; load_val = TW'(LE_SETUP_CYC-1);
            end else begin
               nxt = ST_LO;   load_val = TW'(SCLK_LO_CYC-1);
            end
         end
         ST_LESU: if (expired) begin
            nxt = ST_LEHI; load = 1'b1; load_val = TW'(LE_PULSE_CYC-1);
         end
         ST_LEHI: if (expired) begin
            nxt = ST_GAP; load = 1'b1; load_val = TW'(GAP_CYC-1);
         end
         ST_GAP: if (expired) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         bit_idx  <= '0;
         ser_clk  <= 1'b0;
         ser_data <= 1'b0;
         ser_le   <= 1'b0;
      end else begin
         state   <= nxt;
         ser_clk <= (nxt == ST_HI);
         ser_le  <= (nxt == ST_LEHI);
         if (accept) begin
            shreg    <= word;
            ser_data <= word[0];
            bit_idx  <= '0;
         end else if (state == ST_HI && expired) begin
            if (last_bit) begin
               ser_data <= 1'b0;
            end else begin
               shreg    <= shreg >> 1;
               ser_data <= shreg[1];
               bit_idx  <= bit_idx + 1'b1;
            end
         end
      end
   end

   // R4
   le_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_le |-> !ser_clk);

   // R6
   data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> $stable(ser_data));

   // R6
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R8
   gap_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_le) |-> !ready);

endmodule

// File: rtl/atten_serial_prog.sv
module atten_serial_prog
   import atten_prog_pkg::*;
#(
   parameter int REQ_W          = 8,
   parameter int CODE_W         = 7,
   parameter int SCLK_HI_CYC    = 2,
   parameter int SCLK_LO_CYC    = 3,
   parameter int MIN_PERIOD_CYC = 5,
   parameter int SETUP_CYC      = 1,
   parameter int HOLD_CYC       = 1,
   parameter int LE_SETUP_CYC   = 1,
   parameter int LE_PULSE_CYC   = 2,
   parameter int GAP_CYC        = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [REQ_W-1:0] req_value,
   output logic             req_ready,
   output logic             busy,
   output logic             clamped,
   output logic             ser_clk,
   output logic             ser_data,
   output logic             ser_le
);
   localparam int WORD_W   = CODE_W + 1;
   localparam int MAX_CODE = (1 << CODE_W) - 1;
   localparam int TMR_MAX  = cyc_max(SCLK_HI_CYC, SCLK_LO_CYC, LE_SETUP_CYC,
                                     LE_PULSE_CYC, GAP_CYC);
   localparam int TW       = $clog2(TMR_MAX + 1);

   generate
      if (SCLK_HI_CYC < 1 || SCLK_LO_CYC < 1 || LE_SETUP_CYC < 1 ||
          LE_PULSE_CYC < 1 || GAP_CYC < 1) begin : g_bad_zero
         $error("every phase length must be at least one cycle");
      end
      if (SCLK_LO_CYC < SETUP_CYC) begin : g_bad_setup
         $error("clock low phase shorter than data setup");
      end
      if (SCLK_HI_CYC < HOLD_CYC) begin : g_bad_hold
         $error("clock high phase shorter than data hold");
      end
      if (SCLK_HI_CYC + SCLK_LO_CYC < MIN_PERIOD_CYC) begin : g_bad_period
         $error("serial clock period below minimum");
      end
      if (CODE_W < 1 || REQ_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              over;
   logic              t_load;
   logic [TW-1:0]     t_val;
   logic              t_exp;
   logic              rdy;

   atten_word_build #(.REQ_W(REQ_W), .CODE_W(CODE_W)) u_word (
      .req_value (req_value),
      .word      (word),
      .over      (over)
   );

   atten_phase_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   atten_shift_seq #(
      .WORD_W       (WORD_W),
      .TW           (TW),
      .SCLK_HI_CYC  (SCLK_HI_CYC),
      .SCLK_LO_CYC  (SCLK_LO_CYC),
      .LE_SETUP_CYC (LE_SETUP_CYC),
      .LE_PULSE_CYC (LE_PULSE_CYC),
      .GAP_CYC      (GAP_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .word     (word),
      .expired  (t_exp),
      .load     (t_load),
      .load_val (t_val),
      .ready    (rdy),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_le   (ser_le)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                clamped <= 1'b0;
      else if (req_valid && rdy) clamped <= over;
   end

   assign req_ready = rdy;
   assign busy      = ~rdy;

   // R2
   clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (int'(req_value) > MAX_CODE)) |=> clamped);

   // R8
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!ser_clk && !ser_data && !ser_le));

   // R10
   busy_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(clamped));

endmodule

// File: tb/atten_serial_prog_test.sv
module atten_serial_prog_test;
   localparam int HI  = 3;
   localparam int LO  = 2;
   localparam int LSU = 2;
   localparam int LPW = 3;
   localparam int GAP = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_value = 8'd0;
   logic       req_ready, busy, clamped, ser_clk, ser_data, ser_le;

   int n_chk = 0;
   int n_bad = 0;

   // monitor state
   int cyc = 0;
   int rises = 0, le_rises = 0;
   int lo_run = 0, hi_run = 0;
   int t_last_rise = 0, t_le_rise = 0, t_le_fall = 0, t_rdy = 0;
   bit lo_bad = 0, hi_bad = 0, data_bad = 0, le_early = 0, le_clk = 0;
   logic [7:0] cap = 8'd0;
   logic p_clk = 0, p_data = 0, p_le = 0, p_rdy = 0;

   always #10 clk = ~clk;

   atten_serial_prog #(
      .REQ_W(8), .CODE_W(7), .SCLK_HI_CYC(HI), .SCLK_LO_CYC(LO),
      .MIN_PERIOD_CYC(5), .SETUP_CYC(1), .HOLD_CYC(1),
      .LE_SETUP_CYC(LSU), .LE_PULSE_CYC(LPW), .GAP_CYC(GAP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_value(req_value),
      .req_ready(req_ready), .busy(busy), .clamped(clamped),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (ser_clk && !p_clk) begin
         rises = rises + 1;
         cap = {ser_data, cap[7:1]};
         if (lo_run < LO) lo_bad = 1;
         t_last_rise = cyc;
         hi_run = 1;
      end else if (ser_clk) hi_run = hi_run + 1;
      if (!ser_clk && p_clk) begin
         if (hi_run != HI) hi_bad = 1;
         lo_run = 1;
      end else if (!ser_clk) lo_run = lo_run + 1;
      if (ser_clk && (ser_data != p_data)) data_bad = 1;
      if (ser_le && !p_le) begin
         le_rises = le_rises + 1;
         t_le_rise = cyc;
         if (rises != 8) le_early = 1;
      end
      if (!ser_le && p_le) t_le_fall = cyc;
      if (ser_le && ser_clk) le_clk = 1;
      if (req_ready && !p_rdy) t_rdy = cyc;
      p_clk = ser_clk; p_data = ser_data; p_le = ser_le; p_rdy = req_ready;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic check_reset();
      chk(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
      chk(busy == 1'b0, "R8 busy after reset", int'(busy), 0);
      chk({ser_clk, ser_data, ser_le} == 3'b000, "R9 idle pins", int'({ser_clk, ser_data, ser_le}), 0);
      chk(clamped == 1'b0, "R9 clamped after reset", int'(clamped), 0);
   endtask

   // one full transfer; intrude pulses a second request while busy
   task automatic send(input logic [7:0] v, input bit intrude, input bit exp_clamp_before);
      logic [7:0] exp_w;
      exp_w = (v > 8'd127) ? 8'd127 : v;
      @(negedge clk); #1;
      while (!req_ready) begin @(negedge clk); #1; end
      rises = 0; le_rises = 0; lo_bad = 0; hi_bad = 0; data_bad = 0;
      le_early = 0; le_clk = 0; cap = 8'd0;
      req_valid = 1'b1; req_value = v;
      @(negedge clk); #1;
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 ready drops after accept", int'(req_ready), 0);
      chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
      chk(clamped == (v > 8'd127), "R2 clamped flag", int'(clamped), int'(v > 8'd127));
      if (intrude) begin
         for (int i = 0; i < 5; i++) begin
            req_valid = 1'b1; req_value = 8'd200;
            @(negedge clk); #1;
         end
         req_valid = 1'b0;
         chk(clamped == exp_clamp_before, "R10 flag unchanged by ignored request",
             int'(clamped), int'(exp_clamp_before));
      end
      while (!req_ready) begin @(negedge clk); #1; end
      chk(rises == 8, "R3 rising edge count", rises, 8);
      chk(cap == exp_w, intrude ? "R10 word unchanged by ignored request" : "R1 R3 word on wire",
          int'(cap), int'(exp_w));
      chk(!lo_bad && !hi_bad, "R5 clock phase lengths", int'({lo_bad, hi_bad}), 0);
      chk(!data_bad, "R6 data stable around rise", int'(data_bad), 0);
      chk(le_rises == 1 && !le_early && !le_clk, "R4 single strobe after shift",
          le_rises, 1);
      chk(t_le_fall - t_le_rise == LPW, "R4 strobe width", t_le_fall - t_le_rise, LPW);
      chk(t_le_rise - t_last_rise == HI + LSU, "R7 strobe setup",
          t_le_rise - t_last_rise, HI + LSU);
      chk(t_rdy - t_le_fall == GAP, "R8 dead time after commit", t_rdy - t_le_fall, GAP);
      chk(busy == 1'b0 && {ser_clk, ser_data, ser_le} == 3'b000, "R9 idle after transfer",
          int'({busy, ser_clk, ser_data, ser_le}), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1; check_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1; check_reset();
      send(8'd50,  1'b0, 1'b0);   // R1: 12.5 units -> 0011_0010
      send(8'd0,   1'b0, 1'b0);
      send(8'd127, 1'b0, 1'b0);
      send(8'd1,   1'b0, 1'b0);   // R3: only bit 0 set
      send(8'd64,  1'b0, 1'b0);   // R3: only bit 6 set
      send(8'd170, 1'b0, 1'b0);   // R2: saturates to 127
      send(8'd85,  1'b0, 1'b1);   // R2: flag clears
      send(8'd255, 1'b0, 1'b0);   // R2: top of range
      send(8'd42,  1'b1, 1'b0);   // R10: request while busy ignored
      summary();
   end
endmodule